// File: doc/BRIEF.md
# Nested-Priority Vectored Interrupt Controller

This block arbitrates eight interrupt request lines for a small DSP-style core. Each line can be taken from an external pin or from an internal peripheral request wire, picked one bit per line in a source-select register. Every line has a fixed priority of its index modulo four. The block raises `irq_o` to the core while any selected request has a priority strictly above the current execution level.

When the core pulls the active-low acknowledge strobe low, the block accepts the winning request. It then presents that request's programmable 16-bit vector address on `vec_o` for exactly one cycle. At the same time it raises the current level to the request's priority and pushes the old level onto a four-entry hardware stack, so interrupts can nest. A return pulse pops the stack.

The current level, an empty-stack flag and the four stacked levels are packed into one 16-bit control word. Software can read it and overwrite it directly through a simple memory-mapped port. The same port reaches the eight vector registers and the source-select register.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the control word at address 0x28 reads 0x000B (level 3, empty flag set, all stacked slots 0), the source-select word at 0x29 reads 0, and `irq_o`, `vec_valid_o` and `ovf_o` are low.
- R2: Source-select bit i (address 0x29, bits 7:0) at 0 takes request i from `ext_req_i[i]`; at 1 it takes it from `per_req_i[i]`. Each bit acts on its own line only.
- R3: Request i has priority i mod 4. The current level occupies control bits 2:0 as a 3-bit two's-complement value, with -1 written as 3'b111. `irq_o` is high exactly when some selected request has a priority strictly greater than the current level.
- R4: Among eligible requests the highest priority wins, and a tie goes to the lowest index.
- R5: Vector register i lives at address 0x20+i and is readable and writable. When `ack_ni` is sampled high and then low on consecutive rising edges while a request is eligible, `vec_valid_o` is high for exactly the following cycle, with `vec_o` equal to the winner's vector register.
- R6: On acceptance the current level becomes the winner's priority. The old level moves into slot 1 (bits 6:4), slot 1 moves to slot 2 (bits 9:7), slot 2 to slot 3 (bits 12:10) and slot 3 to slot 4 (bits 15:13). The empty flag (bit 3) clears.
- R7: A `reti_i` pulse with a non-empty stack loads slot 1 into the current level and shifts slots 2 to 4 down by one, with slot 4 filled with 0. The empty flag sets again when the last stacked level is removed.
- R8: Accepting a request while four levels are stacked discards the slot 4 content and sets `ovf_o`, which stays high until reset.
- R9: A `reti_i` pulse on an empty stack leaves the control word unchanged.
- R10: A write to address 0x28 loads the current level and all four slots directly from the written data. Writing the empty flag as 1 marks the stack empty; writing it as 0 marks all four slots as live.
- R11: An acknowledge falling edge with no eligible request changes nothing and produces no `vec_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_req_i | input | 8 | External pin requests, level sensitive |
| per_req_i | input | 8 | Internal peripheral requests, level sensitive |
| reg_addr_i | input | 8 | Register word address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` (combinational) |
| ack_ni | input | 1 | Interrupt acknowledge strobe, active low |
| reti_i | input | 1 | Return-from-interrupt pulse |
| irq_o | output | 1 | Eligible request pending |
| vec_o | output | 16 | Vector of the accepted interrupt, zero when not valid |
| vec_valid_o | output | 1 | `vec_o` carries a vector this cycle |
| ovf_o | output | 1 | Sticky stack overflow |

## Verification
The hardest state to reach from the ports is a push onto a full stack. Fixed priorities top out at 3, so four nested acceptances from level -1 leave the level at 3, and no request can then beat it. The stimulus nests four requests of rising priority, then rewrites the control word with the same slots, the empty flag at 0 and the level set back to -1. A fifth acceptance can then push past the top, which shows both the dropped slot and the sticky overflow.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int unsigned LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_RST = 3'b011;

  function automatic lvl_t prio_of(input int unsigned idx);
    return lvl_t'(idx % 4);
  endfunction

  function automatic logic lvl_gt(input lvl_t a, input lvl_t b);
    return $signed(a) > $signed(b);
  endfunction
endpackage

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int unsigned N_REQ = 8,
  localparam int unsigned IDX_W = $clog2(N_REQ)
) (
  input  logic [N_REQ-1:0] req_i,
  input  lvl_t             cur_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output lvl_t             lvl_o
);
  logic [N_REQ-1:0] elig;

  for (genvar g = 0; g < N_REQ; g++) begin : g_elig
    assign elig[g] = req_i[g] && lvl_gt(prio_of(g), cur_i);
  end

  // descending scan with >= keeps the lowest index on ties
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (elig[i] && (!any_o || !lvl_gt(lvl_o, prio_of(i)))) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        lvl_o = prio_of(i);
      end
    end
  end
endmodule

// File: rtl/nic_level_stack.sv
module nic_level_stack
  import nic_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned FLAT_W = DEPTH * LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  lvl_t              push_lvl_i,
  input  logic              pop_i,
  input  logic              wr_i,
  input  lvl_t              wr_cur_i,
  input  logic              wr_empty_i,
  input  logic [FLAT_W-1:0] wr_slots_i,
  output lvl_t              cur_o,
  output logic [FLAT_W-1:0] slots_o,
  output logic              empty_o,
  output logic              ovf_o
);
  lvl_t             cur_q;
  lvl_t             slot_q [DEPTH];
  logic [CNT_W-1:0] depth_q;
  logic             ovf_q;
  logic             full;

  assign full = depth_q == CNT_W'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= LVL_RST;
      depth_q <= '0;
      ovf_q   <= 1'b0;
      for (int k = 0; k < DEPTH; k++) slot_q[k] <= '0;
    end else if (wr_i) begin
      cur_q   <= wr_cur_i;
      depth_q <= wr_empty_i ? '0 : CNT_W'(DEPTH);
      for (int k = 0; k < DEPTH; k++) slot_q[k] <= wr_slots_i[k*LVL_W +: LVL_W];
    end else if (push_i) begin
      cur_q     <= push_lvl_i;
      slot_q[0] <= cur_q;
      for (int k = 1; k < DEPTH; k++) slot_q[k] <= slot_q[k-1];
      if (full) ovf_q <= 1'b1;
      else      depth_q <= depth_q + 1'b1;
    end else if (pop_i && depth_q != '0) begin
      cur_q <= slot_q[0];
      for (int k = 0; k < DEPTH - 1; k++) slot_q[k] <= slot_q[k+1];
      slot_q[DEPTH-1] <= '0;
      depth_q <= depth_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_pack
    assign slots_o[g*LVL_W +: LVL_W] = slot_q[g];
  end

  assign cur_o   = cur_q;
  assign empty_o = depth_q == '0;
  assign ovf_o   = ovf_q;

  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  a_r8_ovf_on_full_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !wr_i && full) |=> ovf_o);
  a_r6_push_clears_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !wr_i) |=> !empty_o);
  a_r6_push_saves_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !wr_i) |=> (slots_o[LVL_W-1:0] == $past(cur_o)));
  a_r7_pop_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !wr_i && !empty_o) |=> (cur_o == $past(slots_o[LVL_W-1:0])));
  a_r9_pop_empty_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !wr_i && empty_o) |=> ($stable(cur_o) && $stable(slots_o) && empty_o));
endmodule

// File: rtl/nic_vec_file.sv
module nic_vec_file #(
  parameter int unsigned N_REQ = 8,
  parameter int unsigned VEC_W = 16,
  localparam int unsigned IDX_W = $clog2(N_REQ)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [VEC_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [VEC_W-1:0] rdata_o,
  input  logic [IDX_W-1:0] sidx_i,
  output logic [VEC_W-1:0] sdata_o
);
  logic [VEC_W-1:0] mem_q [N_REQ];

  // no reset value by definition
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[ridx_i];
  assign sdata_o = mem_q[sidx_i];
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int unsigned N_REQ    = 8,
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned VEC_BASE = 32'h20,
  parameter int unsigned CTL_ADDR = 32'h28,
  parameter int unsigned SEL_ADDR = 32'h29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_REQ-1:0]  ext_req_i,
  input  logic [N_REQ-1:0]  per_req_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [VEC_W-1:0]  reg_wdata_i,
  output logic [VEC_W-1:0]  reg_rdata_o,
  input  logic              ack_ni,
  input  logic              reti_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_valid_o,
  output logic              ovf_o
);
  localparam int unsigned IDX_W  = $clog2(N_REQ);
  localparam int unsigned FLAT_W = DEPTH * LVL_W;
  localparam int unsigned CTL_W  = FLAT_W + LVL_W + 1;
  localparam logic [ADDR_W-1:0] VEC_A = ADDR_W'(VEC_BASE);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_ADDR);

  logic [N_REQ-1:0]  sel_q;
  logic [N_REQ-1:0]  req;
  logic              ack_q;
  logic              ack_fall;
  logic              accept;
  logic              win_any;
  logic [IDX_W-1:0]  win_idx;
  lvl_t              win_lvl;
  logic [IDX_W-1:0]  svc_idx_q;
  logic              vld_q;
  logic              vec_hit, ctl_hit, sel_hit, ctl_we;
  logic [IDX_W-1:0]  reg_idx;
  logic [VEC_W-1:0]  vec_rd, svc_vec;
  lvl_t              cur;
  logic [FLAT_W-1:0] slots;
  logic              empty;
  logic [CTL_W-1:0]  ctl_word;

  // register decode
  assign vec_hit = (reg_addr_i >= VEC_A) && (reg_addr_i < VEC_A + ADDR_W'(N_REQ));
  assign ctl_hit = reg_addr_i == CTL_A;
  assign sel_hit = reg_addr_i == SEL_A;
  assign reg_idx = IDX_W'(reg_addr_i - VEC_A);
  assign ctl_we  = reg_we_i && ctl_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sel_q <= '0;
    else if (reg_we_i && sel_hit) sel_q <= reg_wdata_i[N_REQ-1:0];
  end

  for (genvar g = 0; g < N_REQ; g++) begin : g_src
    assign req[g] = sel_q[g] ? per_req_i[g] : ext_req_i[g];
  end

  nic_arbiter #(.N_REQ(N_REQ)) u_arb (
    .req_i (req),
    .cur_i (cur),
    .any_o (win_any),
    .idx_o (win_idx),
    .lvl_o (win_lvl)
  );

  // acknowledge edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b1;
    else         ack_q <= ack_ni;
  end

  assign ack_fall = ack_q && !ack_ni;
  assign accept   = ack_fall && win_any && !ctl_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svc_idx_q <= '0;
      vld_q     <= 1'b0;
    end else begin
      vld_q <= accept;
      if (accept) svc_idx_q <= win_idx;
    end
  end

  nic_level_stack #(.DEPTH(DEPTH)) u_stk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (accept),
    .push_lvl_i (win_lvl),
    .pop_i      (reti_i),
    .wr_i       (ctl_we),
    .wr_cur_i   (reg_wdata_i[LVL_W-1:0]),
    .wr_empty_i (reg_wdata_i[LVL_W]),
    .wr_slots_i (reg_wdata_i[CTL_W-1:LVL_W+1]),
    .cur_o      (cur),
    .slots_o    (slots),
    .empty_o    (empty),
    .ovf_o      (ovf_o)
  );

  nic_vec_file #(.N_REQ(N_REQ), .VEC_W(VEC_W)) u_vec (
    .clk_i   (clk_i),
    .we_i    (reg_we_i && vec_hit),
    .widx_i  (reg_idx),
    .wdata_i (reg_wdata_i),
    .ridx_i  (reg_idx),
    .rdata_o (vec_rd),
    .sidx_i  (svc_idx_q),
    .sdata_o (svc_vec)
  );

  assign ctl_word = {slots, empty, cur};

  always_comb begin
    reg_rdata_o = '0;
    if (vec_hit)      reg_rdata_o = vec_rd;
    else if (ctl_hit) reg_rdata_o = VEC_W'(ctl_word);
    else if (sel_hit) reg_rdata_o = VEC_W'(sel_q);
  end

  assign irq_o       = win_any;
  assign vec_valid_o = vld_q;
  assign vec_o       = vld_q ? svc_vec : '0;

  a_r5_vec_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> !vec_valid_o);
  a_r5_vec_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> ($past(ack_q) && !$past(ack_ni)));
  a_r3_irq_above_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> lvl_gt(win_lvl, cur));
  a_r11_no_accept_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fall && !irq_o && !ctl_we) |=> (!vec_valid_o && $stable(ctl_word)));
  a_r6_level_raised: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (cur == $past(win_lvl)));
endmodule

// File: tb/nest_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module nest_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ext_req = '0, per_req = '0, addr = '0;
  logic        we = 1'b0, ack_n = 1'b1, reti = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, vec;
  logic        irq, vld, ovf;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;

  nest_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_req_i(ext_req), .per_req_i(per_req),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ack_ni(ack_n), .reti_i(reti), .irq_o(irq), .vec_o(vec),
    .vec_valid_o(vld), .ovf_o(ovf)
  );

  function automatic logic [15:0] vval(input int i);
    return 16'hA000 + 16'(i * 16'h0111);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    check(tag, rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  // driver: pushes expected vector, then strobes acknowledge
  task automatic ack(input bit expect_vec, input logic [15:0] v);
    if (expect_vec) exp_q.push_back(v);
    @(negedge clk); ack_n = 1'b0;
    @(negedge clk); ack_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ret();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && vld) begin
      if (exp_q.size() == 0) check("R11 unexpected vector", vec, 16'hxxxx);
      else check("R5 vector", vec, exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h28, 16'h000B, "R1 ctl reset");
    rd(8'h29, 16'h0000, "R1 sel reset");
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 ovf", {15'd0, ovf}, 16'd0);
    check("R1 vld", {15'd0, vld}, 16'd0);

    for (int i = 0; i < 8; i++) wr(8'h20 + 8'(i), vval(i));
    rd(8'h21, vval(1), "R5 vec1 readback");
    rd(8'h27, vval(7), "R5 vec7 readback");

    // R3 level 3 masks everything
    ext_req = 8'hFF;
    @(negedge clk); #1 check("R3 masked at level 3", {15'd0, irq}, 16'd0);
    ext_req = 8'h00;
    // R10 direct write: level -1, empty
    wr(8'h28, 16'h000F);
    rd(8'h28, 16'h000F, "R10 ctl write");
    ext_req = 8'h01;
    @(negedge clk); #1 check("R3 prio0 above -1", {15'd0, irq}, 16'd1);

    // R4 tie between idx1 and idx5 at prio1, idx0 lower
    ext_req = 8'h23;
    ack(1, vval(1));
    rd(8'h28, 16'h0071, "R6 push first");
    #1 check("R3 nothing above level 1", {15'd0, irq}, 16'd0);

    // R4 highest priority wins (idx7 prio3 over idx2 prio2)
    ext_req = 8'hA7;
    ack(1, vval(7));
    rd(8'h28, 16'h0393, "R6 push second");

    ext_req = 8'h00;
    ret();
    rd(8'h28, 16'h0071, "R7 pop first");
    ret();
    rd(8'h28, 16'h000F, "R7 pop to empty");
    ret();
    rd(8'h28, 16'h000F, "R9 pop on empty");

    // R2 source select
    per_req = 8'h08;
    @(negedge clk); #1 check("R2 peripheral ignored when sel=0", {15'd0, irq}, 16'd0);
    wr(8'h29, 16'h0008);
    rd(8'h29, 16'h0008, "R2 sel readback");
    #1 check("R2 peripheral selected", {15'd0, irq}, 16'd1);
    ext_req = 8'hF7;
    ack(1, vval(3));
    rd(8'h28, 16'h0073, "R6 push from peripheral");
    ack(0, 16'h0);
    rd(8'h28, 16'h0073, "R11 ack without eligible");
    ret();
    rd(8'h28, 16'h000F, "R7 pop back");
    ext_req = 8'h00; per_req = 8'h00;
    wr(8'h29, 16'h0000);

    // R8 overflow: four nested pushes, lower level by write, push again
    for (int i = 0; i < 4; i++) begin
      ext_req = 8'(1 << i);
      ack(1, vval(i));
    end
    ext_req = 8'h00;
    rd(8'h28, 16'hE0A3, "R6 stack full");
    check("R8 no ovf yet", {15'd0, ovf}, 16'd0);
    wr(8'h28, 16'hE0A7);
    rd(8'h28, 16'hE0A7, "R10 write keeps slots");
    ext_req = 8'h01;
    ack(1, vval(0));
    ext_req = 8'h00;
    rd(8'h28, 16'h0570, "R8 oldest dropped");
    check("R8 ovf set", {15'd0, ovf}, 16'd1);
    ret();
    rd(8'h28, 16'h00A7, "R7 pop after overflow");
    check("R8 ovf sticky", {15'd0, ovf}, 16'd1);

    repeat (3) @(negedge clk);
    while (exp_q.size() != 0) check("R5 missing vector", 16'hxxxx, exp_q.pop_front());
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule